// File: doc/BRIEF.md
# SMI Cause Status Register

This block gathers the causes of a system-management interrupt into one 32-bit status word and drives an active-low interrupt line from them. Software reads the word through a plain register port. The register answers only at a fixed offset, 34h, inside its power-management I/O block.

Three bits are sticky flags. An SMBus event sets the first. A tick from a periodic-rate source sets the second. A snooped I/O access to the embedded-controller ports 62h or 66h sets the third. Software clears each of them by writing a one to its position. A sticky flag raises the interrupt only when its own enable input is high.

Four other bits are live reductions of masked status vectors that arrive from outside: device traps, two general-purpose event groups and power-management status. Any of these four raises the interrupt with no further enable. Two more bits show live cause lines for information only. The interrupt output is registered, so it changes one clock after the condition that drives it.

Top module: `smi_cause_reg`

## Requirements
- R1: After reset the sticky flags are 0 and `smi_n` is 1. `bus_rdata` returns the status word only while `bus_addr` equals 34h and returns 0 at any other offset. A write at another offset changes nothing.
- R2: Bits 31:17 and bit 7 always read 0. Bits 15, 13, 12, 10, 9 and 8 cannot be changed by writes.
- R3: Bit 16 (SMBus) sets on `smbus_msg_evt`. It also sets on `smbus_alert_evt`, but only while `smbus_smi_mode` is 1. An alert while the mode is 0 leaves it unchanged.
- R4: Bit 14 (periodic) sets on each cycle in which `periodic_tick` is 1.
- R5: Bit 11 (embedded-controller access) sets on a cycle with `io_snoop_valid` high and `io_snoop_addr` equal to 0062h or 0066h. Any other address leaves it unchanged.
- R6: Writing 1 to bit 16, 14 or 11 at offset 34h clears that flag after the clock edge. Writing 0 leaves it unchanged. When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R7: Bit 15 follows `serirq_cause` and bit 13 follows `tco_cause` combinationally. Neither is held.
- R8: Bit 12 is OR(`devtrap_sts` & `devtrap_en`). Bit 9 is OR(`gpe0_sts` & `gpe0_en`). Bit 10 is OR(`gpe1_sts` & `gpe1_en` & `gpe1_route`). Bit 8 is OR(`pm1_smi_sts`).
- R9: `smi_n` is 0 in the cycle after one of these holds: bit 16 set with `smbus_smi_en`, bit 14 set with `periodic_en`, bit 11 set with `ec_smi_en`, or any of bits 8, 9, 10 or 12 at 1. Otherwise it is 1 in the cycle after.
- R10: A sticky flag whose enable is 0 does not pull `smi_n` low. Bits 15 and 13 never pull it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 8 | Register offset inside the power-management block |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; a 1 clears a sticky flag |
| bus_rdata | output | 32 | Status word at offset 34h, else 0 |
| io_snoop_valid | input | 1 | A snooped I/O cycle is present |
| io_snoop_addr | input | 16 | Address of the snooped I/O cycle |
| smbus_msg_evt | input | 1 | Pulse when the SMBus slave receives a message |
| smbus_alert_evt | input | 1 | Pulse on an SMBus alert assertion |
| smbus_smi_mode | input | 1 | SMBus host is set to signal SMI rather than normal interrupts |
| smbus_smi_en | input | 1 | Enable for bit 16 |
| periodic_tick | input | 1 | Periodic-rate pulse |
| periodic_en | input | 1 | Enable for bit 14 |
| ec_smi_en | input | 1 | Enable for bit 11 |
| serirq_cause | input | 1 | Live serial-IRQ cause |
| tco_cause | input | 1 | Live TCO cause |
| devtrap_sts | input | 8 | Device-trap status vector |
| devtrap_en | input | 8 | Device-trap enable vector |
| gpe0_sts | input | 16 | Event group 0 status |
| gpe0_en | input | 16 | Event group 0 enable |
| gpe1_sts | input | 16 | Event group 1 status |
| gpe1_en | input | 16 | Event group 1 enable |
| gpe1_route | input | 16 | Per-bit route-to-SMI flag for group 1 |
| pm1_smi_sts | input | 4 | PM1 status bits able to cause SMI |
| smi_n | output | 1 | Active-low system-management interrupt |

## Verification
A sticky flag that is lost, stuck or cleared by the wrong write shows up at `bus_rdata` in the cycle after the edge that corrupted it, as long as the bench holds the address at 34h. A flag held wrongly while its enable is high also moves `smi_n` one clock later. A flag whose enable is low is visible only through the read port. For that reason the bench keeps reading the register on nearly every cycle instead of watching the interrupt line alone. A wrong live reduction shows in the same cycle on `bus_rdata` and one cycle later on `smi_n`.

// File: rtl/smi_pkg.sv
package smi_pkg;

  localparam int STAT_W      = 32;

  localparam int B_SMBUS     = 16;
  localparam int B_SERIRQ    = 15;
  localparam int B_PERIODIC  = 14;
  localparam int B_TCO       = 13;
  localparam int B_DEVTRAP   = 12;
  localparam int B_EC        = 11;
  localparam int B_GPE1      = 10;
  localparam int B_GPE0      = 9;
  localparam int B_PM1       = 8;

  localparam int STK_SMBUS    = 0;
  localparam int STK_PERIODIC = 1;
  localparam int STK_EC       = 2;
  localparam int NUM_STICKY   = 3;

  function automatic int sticky_pos(input int idx);
    case (idx)
      STK_SMBUS:    return B_SMBUS;
      STK_PERIODIC: return B_PERIODIC;
      default:      return B_EC;
    endcase
  endfunction

endpackage

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_d;
  logic upd;

  always_comb begin
    upd = set_i | clr_i;
    q_d = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/smi_masked_or.sv
module smi_masked_or #(
  parameter int N = 8
) (
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] route_i,
  output logic         hit_o
);

  logic [N-1:0] qual;

  for (genvar i = 0; i < N; i++) begin : g_qual
    assign qual[i] = sts_i[i] & en_i[i] & route_i[i];
  end

  assign hit_o = |qual;

endmodule

// File: rtl/smi_io_snoop.sv
module smi_io_snoop #(
  parameter int                   IO_ADDR_W = 16,
  parameter logic [IO_ADDR_W-1:0] PORT_A    = 16'h0062,
  parameter logic [IO_ADDR_W-1:0] PORT_B    = 16'h0066
) (
  input  logic                 valid_i,
  input  logic [IO_ADDR_W-1:0] addr_i,
  output logic                 hit_o
);

  logic match_a;
  logic match_b;

  always_comb begin
    match_a = (addr_i == PORT_A);
    match_b = (addr_i == PORT_B);
    hit_o   = valid_i & (match_a | match_b);
  end

endmodule

// File: rtl/smi_cause_reg.sv
module smi_cause_reg
  import smi_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h34,
  parameter int                IO_ADDR_W  = 16,
  parameter int                N_DEVTRAP  = 8,
  parameter int                N_GPE0     = 16,
  parameter int                N_GPE1     = 16,
  parameter int                N_PM1      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [STAT_W-1:0]    bus_wdata,
  output logic [STAT_W-1:0]    bus_rdata,
  input  logic                 io_snoop_valid,
  input  logic [IO_ADDR_W-1:0] io_snoop_addr,
  input  logic                 smbus_msg_evt,
  input  logic                 smbus_alert_evt,
  input  logic                 smbus_smi_mode,
  input  logic                 smbus_smi_en,
  input  logic                 periodic_tick,
  input  logic                 periodic_en,
  input  logic                 ec_smi_en,
  input  logic                 serirq_cause,
  input  logic                 tco_cause,
  input  logic [N_DEVTRAP-1:0] devtrap_sts,
  input  logic [N_DEVTRAP-1:0] devtrap_en,
  input  logic [N_GPE0-1:0]    gpe0_sts,
  input  logic [N_GPE0-1:0]    gpe0_en,
  input  logic [N_GPE1-1:0]    gpe1_sts,
  input  logic [N_GPE1-1:0]    gpe1_en,
  input  logic [N_GPE1-1:0]    gpe1_route,
  input  logic [N_PM1-1:0]     pm1_smi_sts,
  output logic                 smi_n
);

  localparam logic [IO_ADDR_W-1:0] EC_PORT_DATA = IO_ADDR_W'(16'h0062);
  localparam logic [IO_ADDR_W-1:0] EC_PORT_CMD  = IO_ADDR_W'(16'h0066);

  logic                  reg_sel;
  logic                  wr_hit;
  logic                  ec_hit;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_clr;
  logic [NUM_STICKY-1:0] sticky_q;
  logic [NUM_STICKY-1:0] sticky_en;
  logic                  devtrap_hit;
  logic                  gpe0_hit;
  logic                  gpe1_hit;
  logic                  pm1_hit;
  logic [STAT_W-1:0]     status;
  logic                  smi_cond;
  logic                  smi_n_d;
  logic                  smi_n_q;
  logic                  unused_wdata;

  // Address decode and event qualification
  always_comb begin
    reg_sel = (bus_addr == REG_OFFSET);
    wr_hit  = bus_we & reg_sel;
    sticky_set[STK_SMBUS]    = smbus_msg_evt | (smbus_alert_evt & smbus_smi_mode);
    sticky_set[STK_PERIODIC] = periodic_tick;
    sticky_set[STK_EC]       = ec_hit;
    sticky_en[STK_SMBUS]     = smbus_smi_en;
    sticky_en[STK_PERIODIC]  = periodic_en;
    sticky_en[STK_EC]        = ec_smi_en;
  end

  assign unused_wdata = ^bus_wdata;

  smi_io_snoop #(
    .IO_ADDR_W (IO_ADDR_W),
    .PORT_A    (EC_PORT_DATA),
    .PORT_B    (EC_PORT_CMD)
  ) u_snoop (
    .valid_i (io_snoop_valid),
    .addr_i  (io_snoop_addr),
    .hit_o   (ec_hit)
  );

  // Sticky write-one-to-clear flags
  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    assign sticky_clr[i] = wr_hit & bus_wdata[sticky_pos(i)];
    smi_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sticky_set[i]),
      .clr_i (sticky_clr[i]),
      .q_o   (sticky_q[i])
    );
  end

  // Live masked reductions
  smi_masked_or #(.N(N_DEVTRAP)) u_devtrap (
    .sts_i (devtrap_sts), .en_i (devtrap_en), .route_i ({N_DEVTRAP{1'b1}}),
    .hit_o (devtrap_hit)
  );

  smi_masked_or #(.N(N_GPE0)) u_gpe0 (
    .sts_i (gpe0_sts), .en_i (gpe0_en), .route_i ({N_GPE0{1'b1}}),
    .hit_o (gpe0_hit)
  );

  smi_masked_or #(.N(N_GPE1)) u_gpe1 (
    .sts_i (gpe1_sts), .en_i (gpe1_en), .route_i (gpe1_route),
    .hit_o (gpe1_hit)
  );

  smi_masked_or #(.N(N_PM1)) u_pm1 (
    .sts_i (pm1_smi_sts), .en_i ({N_PM1{1'b1}}), .route_i ({N_PM1{1'b1}}),
    .hit_o (pm1_hit)
  );

  // Status word assembly
  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_STICKY; i++) begin
      status[sticky_pos(i)] = sticky_q[i];
    end
    status[B_SERIRQ]  = serirq_cause;
    status[B_TCO]     = tco_cause;
    status[B_DEVTRAP] = devtrap_hit;
    status[B_GPE1]    = gpe1_hit;
    status[B_GPE0]    = gpe0_hit;
    status[B_PM1]     = pm1_hit;
    bus_rdata = reg_sel ? status : '0;
  end

  // Interrupt next-state and register
  always_comb begin
    smi_cond = (|(sticky_q & sticky_en)) | devtrap_hit | gpe0_hit | gpe1_hit | pm1_hit;
    smi_n_d  = ~smi_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_n_q <= 1'b1;
    end else begin
      smi_n_q <= smi_n_d;
    end
  end

  assign smi_n = smi_n_q;

  assert_smi_assert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_q[STK_PERIODIC] && periodic_en) || (sticky_q[STK_EC] && ec_smi_en) ||
     (sticky_q[STK_SMBUS] && smbus_smi_en) || devtrap_hit || gpe0_hit || gpe1_hit || pm1_hit)
    |=> !smi_n);

  assert_smi_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(sticky_q & sticky_en)) && !devtrap_hit && !gpe0_hit && !gpe1_hit && !pm1_hit)
    |=> smi_n);

  assert_ec_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_snoop_valid && (io_snoop_addr == EC_PORT_DATA || io_snoop_addr == EC_PORT_CMD))
    |=> sticky_q[STK_EC]);

  assert_alert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_q[STK_SMBUS] && !smbus_msg_evt && !smbus_smi_mode) |=> !sticky_q[STK_SMBUS]);

endmodule

// File: tb/smi_cause_reg_tb.sv
`timescale 1ns/1ps
module smi_cause_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        io_snoop_valid;
  logic [15:0] io_snoop_addr;
  logic        smbus_msg_evt, smbus_alert_evt, smbus_smi_mode, smbus_smi_en;
  logic        periodic_tick, periodic_en, ec_smi_en;
  logic        serirq_cause, tco_cause;
  logic [7:0]  devtrap_sts, devtrap_en;
  logic [15:0] gpe0_sts, gpe0_en, gpe1_sts, gpe1_en, gpe1_route;
  logic [3:0]  pm1_smi_sts;
  logic        smi_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference state
  bit m_smb, m_per, m_ec, m_smi_n;

  smi_cause_reg u_dut (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .io_snoop_valid, .io_snoop_addr,
    .smbus_msg_evt, .smbus_alert_evt, .smbus_smi_mode, .smbus_smi_en,
    .periodic_tick, .periodic_en, .ec_smi_en,
    .serirq_cause, .tco_cause,
    .devtrap_sts, .devtrap_en, .gpe0_sts, .gpe0_en,
    .gpe1_sts, .gpe1_en, .gpe1_route, .pm1_smi_sts, .smi_n
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Live parts of the word, per requirement R7 and R8
  function automatic bit live_dev();  return |(devtrap_sts & devtrap_en); endfunction
  function automatic bit live_g0();   return |(gpe0_sts & gpe0_en); endfunction
  function automatic bit live_g1();   return |(gpe1_sts & gpe1_en & gpe1_route); endfunction
  function automatic bit live_pm();   return |pm1_smi_sts; endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = 32'h0;
    if (bus_addr == 8'h34) begin
      w[16] = m_smb;    w[15] = serirq_cause; w[14] = m_per;   w[13] = tco_cause;
      w[12] = live_dev(); w[11] = m_ec;     w[10] = live_g1(); w[9] = live_g0();
      w[8]  = live_pm();
    end
    return w;
  endfunction

  // Behavioural reference, advanced on each clock
  always @(posedge clk or negedge rst_n) begin
    bit cond, wr, s_smb, s_ec;
    if (!rst_n) begin
      m_smb = 0; m_per = 0; m_ec = 0; m_smi_n = 1;
    end else begin
      cond = (m_smb && smbus_smi_en) || (m_per && periodic_en) || (m_ec && ec_smi_en) ||
             live_dev() || live_g0() || live_g1() || live_pm();
      wr    = bus_we && (bus_addr == 8'h34);
      s_smb = smbus_msg_evt || (smbus_alert_evt && smbus_smi_mode);
      s_ec  = io_snoop_valid && (io_snoop_addr == 16'h0062 || io_snoop_addr == 16'h0066);
      if (s_smb) m_smb = 1; else if (wr && bus_wdata[16]) m_smb = 0;
      if (periodic_tick) m_per = 1; else if (wr && bus_wdata[14]) m_per = 0;
      if (s_ec) m_ec = 1; else if (wr && bus_wdata[11]) m_ec = 0;
      m_smi_n = !cond;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] e;
      e = exp_word();
      check("R2 reserved",   bus_rdata & 32'hFFFE_0080, e & 32'hFFFE_0080);
      check("R3 smbus",      bus_rdata & 32'h0001_0000, e & 32'h0001_0000);
      check("R4 periodic",   bus_rdata & 32'h0000_4000, e & 32'h0000_4000);
      check("R5 ec",         bus_rdata & 32'h0000_0800, e & 32'h0000_0800);
      check("R7 live",       bus_rdata & 32'h0000_A000, e & 32'h0000_A000);
      check("R8 reductions", bus_rdata & 32'h0000_1700, e & 32'h0000_1700);
      check("R9 smi_n",      {31'h0, smi_n}, {31'h0, m_smi_n});
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    bus_addr = 8'h34; bus_we = 0; bus_wdata = 0;
    io_snoop_valid = 0; io_snoop_addr = 0;
    smbus_msg_evt = 0; smbus_alert_evt = 0; smbus_smi_mode = 0; smbus_smi_en = 0;
    periodic_tick = 0; periodic_en = 0; ec_smi_en = 0;
    serirq_cause = 0; tco_cause = 0;
    devtrap_sts = 0; devtrap_en = 0; gpe0_sts = 0; gpe0_en = 0;
    gpe1_sts = 0; gpe1_en = 0; gpe1_route = 0; pm1_smi_sts = 0;
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();
    check("R1 reset word", bus_rdata, 32'h0);
    check("R1 reset smi_n", {31'h0, smi_n}, 32'h1);

    // R10: periodic flag without enable keeps smi_n high
    periodic_tick = 1; step(); periodic_tick = 0; step(); step();
    check("R4 periodic set", bus_rdata, 32'h0000_4000);
    check("R10 disabled flag", {31'h0, smi_n}, 32'h1);

    // R1: clearing write at another offset is ignored
    bus_addr = 8'h30; bus_we = 1; bus_wdata = 32'hFFFF_FFFF; step();
    bus_we = 0; check("R1 other offset reads 0", bus_rdata, 32'h0);
    bus_addr = 8'h34; step();
    check("R1 foreign write ignored", bus_rdata, 32'h0000_4000);

    // R6: writing zeros has no effect, writing one clears
    bus_we = 1; bus_wdata = 32'h0; step(); bus_we = 0; step();
    check("R6 write 0 keeps flag", bus_rdata, 32'h0000_4000);
    bus_we = 1; bus_wdata = 32'h0000_4000; step(); bus_we = 0; step();
    check("R6 write 1 clears", bus_rdata, 32'h0);

    // R3: alert without SMI mode ignored, with SMI mode sets
    smbus_alert_evt = 1; step(); smbus_alert_evt = 0; step();
    check("R3 alert ignored", bus_rdata, 32'h0);
    smbus_smi_mode = 1; smbus_alert_evt = 1; step(); smbus_alert_evt = 0; smbus_smi_mode = 0; step();
    check("R3 alert sets", bus_rdata, 32'h0001_0000);

    // R6: set and clear in the same cycle, set wins
    smbus_msg_evt = 1; bus_we = 1; bus_wdata = 32'h0001_0000; step();
    smbus_msg_evt = 0; bus_we = 0; step();
    check("R6 set wins", bus_rdata, 32'h0001_0000);

    // R9: enable raises smi_n one clock later
    smbus_smi_en = 1; step();
    check("R9 enabled flag asserts", {31'h0, smi_n}, 32'h0);
    bus_we = 1; bus_wdata = 32'h0001_0000; step(); bus_we = 0; step(); step();
    check("R9 deasserts after clear", {31'h0, smi_n}, 32'h1);

    // R5: snoop of 63h ignored, 66h sets
    io_snoop_valid = 1; io_snoop_addr = 16'h0063; step(); io_snoop_valid = 0; step();
    check("R5 other port ignored", bus_rdata, 32'h0);
    io_snoop_valid = 1; io_snoop_addr = 16'h0066; step(); io_snoop_valid = 0; step();
    check("R5 port 66h sets", bus_rdata, 32'h0000_0800);

    // R10: live cause lines never assert smi_n
    serirq_cause = 1; tco_cause = 1; step(); step();
    check("R10 live causes", {31'h0, smi_n}, 32'h1);
    check("R7 live causes read", bus_rdata, 32'h0000_A800);
    // R2: write-all-ones only affects sticky flags
    bus_we = 1; bus_wdata = 32'hFFFF_FFFF; step(); bus_we = 0; step();
    check("R2 write all ones", bus_rdata, 32'h0000_A000);
    serirq_cause = 0; tco_cause = 0;

    // R8: group 1 needs route; pm1 asserts with no enable
    gpe1_sts = 16'h0010; gpe1_en = 16'h0010; gpe1_route = 16'h0000; step(); step();
    check("R8 unrouted gpe1", bus_rdata, 32'h0);
    gpe1_route = 16'h0010; step();
    check("R8 routed gpe1", bus_rdata, 32'h0000_0400);
    gpe1_sts = 0; pm1_smi_sts = 4'h2; step();
    check("R8 pm1 bit", bus_rdata, 32'h0000_0100);
    check("R9 from gpe1", {31'h0, smi_n}, 32'h0);
    pm1_smi_sts = 0; step(); step();

    // Random phase, compared every cycle against the reference
    for (int n = 0; n < 4000; n++) begin
      bus_addr        = ($urandom % 8 == 0) ? 8'($urandom) : 8'h34;
      bus_we          = ($urandom % 6 == 0);
      bus_wdata       = $urandom;
      io_snoop_valid  = ($urandom % 5 == 0);
      case ($urandom % 4)
        0: io_snoop_addr = 16'h0062;
        1: io_snoop_addr = 16'h0066;
        2: io_snoop_addr = 16'h0064;
        default: io_snoop_addr = 16'($urandom);
      endcase
      smbus_msg_evt   = ($urandom % 10 == 0);
      smbus_alert_evt = ($urandom % 8 == 0);
      smbus_smi_mode  = $urandom % 2;
      smbus_smi_en    = $urandom % 2;
      periodic_tick   = ($urandom % 9 == 0);
      periodic_en     = $urandom % 2;
      ec_smi_en       = $urandom % 2;
      serirq_cause    = $urandom % 2;
      tco_cause       = $urandom % 2;
      devtrap_sts     = 8'($urandom & $urandom & $urandom);
      devtrap_en      = 8'($urandom & $urandom);
      gpe0_sts        = 16'($urandom & $urandom & $urandom & $urandom);
      gpe0_en         = 16'($urandom & $urandom);
      gpe1_sts        = 16'($urandom & $urandom & $urandom);
      gpe1_en         = 16'($urandom & $urandom);
      gpe1_route      = 16'($urandom & $urandom);
      pm1_smi_sts     = ($urandom % 12 == 0) ? 4'($urandom) : 4'h0;
      step();
    end

    idle_inputs();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule